// File: doc/BRIEF.md
# Adaptive Promotion Threshold Controller

This block sits beside a core's private L1 and judges how well each privately held line is used. It keeps one saturating use counter per L1 line index. A fill clears the counter and every L1 hit on that index adds one. When another core's write invalidates a line, the block returns a registered verdict one cycle later. The verdict says whether the line is granted privately again or demoted to word-granular remote access. The comparison is against a fixed base threshold.

The block also keeps the core's promotion threshold, which the directory-side classifier reads when deciding whether to promote a remotely accessed line. The threshold follows the cache pressure that capacity evictions reveal. When a victim was poorly used, the threshold climbs by one step toward its ceiling, so fewer lines get promoted. When a victim still earned its place, the threshold drops straight back to the base value. With the default parameters there are two levels, 4 and 16, so one step is 12.

Top module: `adapt_thr_ctrl`

## Requirements
- R1: After reset `thr_o` is 4, `dec_vld_o` is 0, and every line's use counter is 0, so an invalidation of any line is answered with demote.
- R2: A hit adds one to the counter of `hit_idx`. The counter holds at 31 and does not wrap to 0.
- R3: A fill sets the counter of `fill_idx` to 0. A fill wins over a hit or an invalidation on the same index in the same cycle.
- R4: An invalidation drives `dec_vld_o` high on the next cycle, with `dec_idx_o` equal to the invalidated index. `dec_keep_o` is 1 exactly when that line's counter is at least 4. The counter value used is the one held before the invalidation cycle, so a hit in the same cycle is not counted. `dec_vld_o` is 0 in every cycle that does not follow an invalidation.
- R5: A demoted line's counter becomes 0. A line granted privately again keeps its counter.
- R6: A capacity eviction whose victim utilization is below 4 raises `thr_o` by 12, holding at 16. `thr_o` always stays between 4 and 16.
- R7: A capacity eviction whose victim utilization is at least 4 sets `thr_o` to 4.
- R8: `thr_o` is registered. It changes only on the cycle after an eviction and stays stable otherwise.
- R9: An invalidation and an eviction in the same cycle are both served. The eviction updates the threshold, and the invalidation verdict still uses the fixed base threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_vld | input | 1 | A line is filled into the L1 |
| fill_idx | input | 3 | Index of the filled line |
| hit_vld | input | 1 | L1 hit event |
| hit_idx | input | 3 | Index of the line hit |
| inv_vld | input | 1 | Invalidation from another core's write |
| inv_idx | input | 3 | Index of the invalidated line |
| evict_vld | input | 1 | Capacity eviction notice |
| evict_util | input | 5 | Utilization of the evicted victim |
| dec_vld_o | output | 1 | Invalidation verdict valid |
| dec_idx_o | output | 3 | Index the verdict refers to |
| dec_keep_o | output | 1 | 1 = grant privately again, 0 = demote |
| thr_o | output | 5 | Current promotion threshold |

## Verification
The bench checks the exact boundary of 4 against 3 hits. A comparator that is off by one either demotes a line that has 4 hits or keeps one that has 3. It then counts 33 hits on a single line. A counter that wraps would fall back to 1, and the line would be wrongly demoted. The bench also places a fill or a hit in the same cycle as an invalidation, and a design with the wrong priority or a bypassed hit gives the wrong verdict on that line or on a later invalidation. Repeated poor evictions test whether the threshold holds at 16 instead of overshooting. A good eviction must snap it back to 4 rather than stepping it down. The rest of the run is random traffic, checked cycle by cycle against a behavioural model.

// File: rtl/apt_pkg.sv
package apt_pkg;
    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_INC,
        CNT_CLR
    } cnt_op_e;
endpackage

// File: rtl/apt_util_bank.sv
module apt_util_bank #(
    parameter int NUM_LINES = 8,
    parameter int UTIL_W    = 5,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_vld,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              hit_vld,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic              clr_vld,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [UTIL_W-1:0] rd_cnt
);
    import apt_pkg::*;

    logic [UTIL_W-1:0] cnt_q [NUM_LINES];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        cnt_op_e           op;
        logic [UTIL_W-1:0] cnt_d;

        always_comb begin
            // fill beats demote-clear, which beats a hit
            if (fill_vld && fill_idx == IDX_W'(l))
                op = CNT_CLR;
            else if (clr_vld && clr_idx == IDX_W'(l))
                op = CNT_CLR;
            else if (hit_vld && hit_idx == IDX_W'(l))
                op = CNT_INC;
            else
                op = CNT_HOLD;

            case (op)
                CNT_CLR: cnt_d = '0;
                CNT_INC: cnt_d = (&cnt_q[l]) ? cnt_q[l] : cnt_q[l] + 1'b1;
                default: cnt_d = cnt_q[l];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q[l] <= '0;
            else        cnt_q[l] <= cnt_d;
        end
    end

    assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/apt_thr_unit.sv
module apt_thr_unit #(
    parameter int UTIL_W   = 5,
    parameter int THR_W    = 5,
    parameter int BASE_THR = 4,
    parameter int MAX_THR  = 16,
    parameter int STEP     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_vld,
    input  logic [UTIL_W-1:0] evict_util,
    output logic [THR_W-1:0]  thr_o
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
    } thr_st_t;

    thr_st_t        st_d, st_q;
    logic           victim_good;
    logic [THR_W:0] raised;

    always_comb begin
        st_d        = st_q;
        victim_good = evict_util >= UTIL_W'(BASE_THR);
        raised      = {1'b0, st_q.thr} + (THR_W+1)'(STEP);
        if (evict_vld) begin
            if (victim_good)
                st_d.thr = THR_W'(BASE_THR);
            else if (raised > (THR_W+1)'(MAX_THR))
                st_d.thr = THR_W'(MAX_THR);
            else
                st_d.thr = raised[THR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{thr: THR_W'(BASE_THR)};
        else        st_q <= st_d;
    end

    assign thr_o = st_q.thr;
endmodule

// File: rtl/adapt_thr_ctrl.sv
module adapt_thr_ctrl #(
    parameter int NUM_LINES = 8,
    parameter int UTIL_W    = 5,
    parameter int BASE_THR  = 4,
    parameter int MAX_THR   = 16,
    parameter int LEVELS    = 2,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int THR_W    = $clog2(MAX_THR + 1),
    localparam int STEP     = (MAX_THR - BASE_THR) / (LEVELS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_vld,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              hit_vld,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic              inv_vld,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              evict_vld,
    input  logic [UTIL_W-1:0] evict_util,
    output logic              dec_vld_o,
    output logic [IDX_W-1:0]  dec_idx_o,
    output logic              dec_keep_o,
    output logic [THR_W-1:0]  thr_o
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic             keep;
    } dec_st_t;

    dec_st_t           dec_d, dec_q;
    logic [UTIL_W-1:0] inv_cnt;
    logic              qualifies;
    logic              demote;

    apt_util_bank #(
        .NUM_LINES (NUM_LINES),
        .UTIL_W    (UTIL_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_vld (fill_vld),
        .fill_idx (fill_idx),
        .hit_vld  (hit_vld),
        .hit_idx  (hit_idx),
        .clr_vld  (demote),
        .clr_idx  (inv_idx),
        .rd_idx   (inv_idx),
        .rd_cnt   (inv_cnt)
    );

    apt_thr_unit #(
        .UTIL_W   (UTIL_W),
        .THR_W    (THR_W),
        .BASE_THR (BASE_THR),
        .MAX_THR  (MAX_THR),
        .STEP     (STEP)
    ) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .evict_vld  (evict_vld),
        .evict_util (evict_util),
        .thr_o      (thr_o)
    );

    always_comb begin
        qualifies  = inv_cnt >= UTIL_W'(BASE_THR);
        demote     = inv_vld && !qualifies;
        dec_d      = dec_q;
        dec_d.vld  = inv_vld;
        if (inv_vld) begin
            dec_d.idx  = inv_idx;
            dec_d.keep = qualifies;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_vld_o  = dec_q.vld;
    assign dec_idx_o  = dec_q.idx;
    assign dec_keep_o = dec_q.keep;
endmodule

// File: rtl/adapt_thr_chk.sv
module adapt_thr_chk #(
    parameter int UTIL_W   = 5,
    parameter int IDX_W    = 3,
    parameter int THR_W    = 5,
    parameter int BASE_THR = 4,
    parameter int MAX_THR  = 16,
    parameter int STEP     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_vld,
    input logic [IDX_W-1:0]  inv_idx,
    input logic              evict_vld,
    input logic [UTIL_W-1:0] evict_util,
    input logic              dec_vld_o,
    input logic [IDX_W-1:0]  dec_idx_o,
    input logic [THR_W-1:0]  thr_o
);
    AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        thr_o >= THR_W'(BASE_THR) && thr_o <= THR_W'(MAX_THR)); // R6

    AST_GOOD_EVICT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld && evict_util >= UTIL_W'(BASE_THR) |=> thr_o == THR_W'(BASE_THR)); // R7

    AST_POOR_EVICT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld && evict_util < UTIL_W'(BASE_THR) |=>
            (int'($past(thr_o)) + STEP > MAX_THR ? thr_o == THR_W'(MAX_THR)
                                                 : int'(thr_o) == int'($past(thr_o)) + STEP)); // R6

    AST_THR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_vld |=> $stable(thr_o)); // R8

    AST_DEC_FOLLOWS_INV: assert property (@(posedge clk) disable iff (!rst_n)
        inv_vld |=> dec_vld_o && dec_idx_o == $past(inv_idx)); // R4

    AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_vld |=> !dec_vld_o); // R4
endmodule

bind adapt_thr_ctrl adapt_thr_chk #(
    .UTIL_W   (UTIL_W),
    .IDX_W    (IDX_W),
    .THR_W    (THR_W),
    .BASE_THR (BASE_THR),
    .MAX_THR  (MAX_THR),
    .STEP     (STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_vld    (inv_vld),
    .inv_idx    (inv_idx),
    .evict_vld  (evict_vld),
    .evict_util (evict_util),
    .dec_vld_o  (dec_vld_o),
    .dec_idx_o  (dec_idx_o),
    .thr_o      (thr_o)
);

// File: tb/sim_adapt_thr_ctrl.sv
`timescale 1ns/1ps
module sim_adapt_thr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fill_vld = 0, hit_vld = 0, inv_vld = 0, evict_vld = 0;
    logic [2:0] fill_idx = 0, hit_idx = 0, inv_idx = 0;
    logic [4:0] evict_util = 0;
    logic       dec_vld_o, dec_keep_o;
    logic [2:0] dec_idx_o;
    logic [4:0] thr_o;

    int n_chk = 0, n_bad = 0;
    int m_cnt [8];
    int m_thr;
    bit m_dvld, m_dkeep;
    int m_didx;

    always #5 clk = ~clk;

    adapt_thr_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_vld(fill_vld), .fill_idx(fill_idx),
        .hit_vld(hit_vld), .hit_idx(hit_idx),
        .inv_vld(inv_vld), .inv_idx(inv_idx),
        .evict_vld(evict_vld), .evict_util(evict_util),
        .dec_vld_o(dec_vld_o), .dec_idx_o(dec_idx_o),
        .dec_keep_o(dec_keep_o), .thr_o(thr_o)
    );

    task automatic compare(string tag);
        n_chk++;
        if (int'(thr_o) != m_thr) begin
            n_bad++;
            $display("FAIL %s thr_o: actual %0d expected %0d", tag, thr_o, m_thr);
        end
        n_chk++;
        if (dec_vld_o !== m_dvld ||
            (m_dvld && (int'(dec_idx_o) != m_didx || dec_keep_o !== m_dkeep))) begin
            n_bad++;
            $display("FAIL %s verdict: actual vld%0d idx%0d keep%0d expected vld%0d idx%0d keep%0d",
                     tag, dec_vld_o, dec_idx_o, dec_keep_o, m_dvld, m_didx, m_dkeep);
        end
    endtask

    // drive one cycle of stimulus, advance the model, check at the next negedge
    task automatic cyc(bit f, int fi, bit h, int hi, bit iv, int ii, bit ev, int eu, string tag);
        bit keep;
        fill_vld = f;  fill_idx = 3'(fi);
        hit_vld = h;   hit_idx = 3'(hi);
        inv_vld = iv;  inv_idx = 3'(ii);
        evict_vld = ev; evict_util = 5'(eu);
        keep = m_cnt[ii] >= 4;
        m_dvld = iv;
        if (iv) begin m_didx = ii; m_dkeep = keep; end
        for (int l = 0; l < 8; l++) begin
            if (f && fi == l) m_cnt[l] = 0;
            else if (iv && ii == l && !keep) m_cnt[l] = 0;
            else if (h && hi == l) m_cnt[l] = (m_cnt[l] >= 31) ? 31 : m_cnt[l] + 1;
        end
        if (ev) m_thr = (eu >= 4) ? 4 : ((m_thr + 12 > 16) ? 16 : m_thr + 12);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic hits(int idx, int n, string tag);
        for (int k = 0; k < n; k++) cyc(0, 0, 1, idx, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int l = 0; l < 8; l++) m_cnt[l] = 0;
        m_thr = 4; m_dvld = 0; m_dkeep = 0; m_didx = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R1");          // untouched line demoted
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R4");
        hits(1, 33, "R2");                          // saturates at 31, must stay >=4
        cyc(0, 0, 0, 0, 1, 1, 0, 0, "R2");
        hits(2, 5, "R3");
        cyc(1, 2, 1, 2, 0, 0, 0, 0, "R3");          // fill beats hit
        cyc(0, 0, 0, 0, 1, 2, 0, 0, "R3");
        hits(5, 5, "R3");
        cyc(1, 5, 0, 0, 1, 5, 0, 0, "R3");          // verdict from old count, then cleared
        cyc(0, 0, 0, 0, 1, 5, 0, 0, "R3");
        hits(3, 4, "R4");                           // exactly 4: keep
        cyc(0, 0, 0, 0, 1, 3, 0, 0, "R4");
        cyc(0, 0, 0, 0, 1, 3, 0, 0, "R5");          // kept count retained
        hits(4, 3, "R4");
        cyc(0, 0, 1, 4, 1, 4, 0, 0, "R4");          // same-cycle hit not counted
        cyc(0, 0, 1, 4, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 1, 4, 0, 0, "R5");          // cleared: 1 hit only
        cyc(0, 0, 0, 0, 0, 0, 1, 3, "R6");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R6");          // holds at 16
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 1, 4, "R7");
        cyc(0, 0, 0, 0, 0, 0, 1, 2, "R6");
        cyc(0, 0, 0, 0, 0, 0, 1, 31, "R7");
        hits(6, 4, "R9");
        cyc(0, 0, 0, 0, 1, 6, 1, 1, "R9");
        cyc(0, 0, 0, 0, 1, 0, 1, 9, "R9");
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            cyc(r < 6, $urandom_range(0, 7), r < 70, $urandom_range(0, 3),
                $urandom_range(0, 9) == 0, $urandom_range(0, 3),
                $urandom_range(0, 6) == 0, $urandom_range(0, 8), "R8");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule